// File: doc/BRIEF.md
# Compare-Value Timer Channel

This block is a single channel of a system compare timer. It watches a free-running 64-bit count supplied from outside. From a stored 64-bit compare value and a small control word it decides whether the programmed deadline has been reached, and it drives a level interrupt while the deadline stands, the channel is on and the interrupt is not masked. A parameter picks the flavour. The virtual flavour subtracts a programmable offset from the count before comparing. The physical flavour compares against the raw count.

Software reaches four registers through a simple write port and a registered read port. It can program the deadline in two ways: as an absolute compare value, or as a signed 32-bit distance from the current adjusted count. It can read the remaining distance back. The control word holds an enable bit, a mask bit and a status flag that can only be read. Status and interrupt are recomputed every cycle from the live count, so any register write takes effect on the next evaluation.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset, the compare value, control word and offset are all zero, the interrupt output is low, and the control read returns 0.
- R2: The status flag is control read bit 2. It is 1 exactly when the channel is enabled and (count − offset) ≥ compare, using unsigned 64-bit arithmetic.
- R3: The output irq_o is registered. It is high in the cycle after a clock edge at which enable=1, status=1 and mask=0 held, and low otherwise.
- R4: While enable (control bit 0) is 0, the status flag reads 0 and irq_o stays low, whatever the compare result.
- R5: A control write (wr_sel=2) stores wr_data[0] as enable and wr_data[1] as mask. Writing wr_data[2] has no effect on the status flag.
- R6: A relative write (wr_sel=1) sets compare = (count − offset) + sign-extended wr_data[31:0], using the count at the write edge.
- R7: The offset register is selected by wr_sel=3. In the virtual variant (IS_VIRTUAL=1) it is writable and used in the comparison. In the physical variant the offset is fixed at 0: writes are ignored and it reads 0.
- R8: A relative read (rd_sel=1) returns the low 32 bits of compare − (count − offset), zero-extended to 64 bits.
- R9: The comparison wraps without sign. A compare value near 2^64 is not reached by a small count, and a count below the offset gives a large adjusted count that fires.
- R10: The mask bit only gates irq_o. The status flag still reads 1 while masked. Clearing the mask raises irq_o one cycle later with no further write.
- R11: A read (rd_en=1) loads rd_data at the next clock edge: compare for rd_sel=0, relative value for 1, {61 zeros, status, mask, enable} for 2, and offset for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Free-running system count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 compare, 1 relative, 2 control, 3 offset |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 64 | Registered read data |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
Two events can land on the same edge: the adjusted count crossing the compare value, and a control write that changes the mask. The bench produces this by moving the count past the deadline in the same cycle that it clears the mask. It then expects the interrupt exactly one cycle later, with the status read still showing 1. A second case pairs a relative write with a count that is moving, to confirm that the count latched at the write edge is the one that sets the new compare value.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  typedef enum logic [1:0] {
    SEL_ABS = 2'd0,
    SEL_REL = 2'd1,
    SEL_CTL = 2'd2,
    SEL_OFS = 2'd3
  } sel_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_STAT_BIT = 2;

  typedef struct packed {
    logic mask;
    logic en;
  } ctl_t;
endpackage

// File: rtl/cvt_regs.sv
module cvt_regs #(
  parameter int CW         = 64,
  parameter int RW         = 32,
  parameter bit IS_VIRTUAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic [CW-1:0] adj_cnt,
  output logic [CW-1:0] cmp_q,
  output cvt_pkg::ctl_t ctl_q,
  output logic [CW-1:0] ofs_q
);
  import cvt_pkg::*;

  localparam int EXT_W = CW - RW;

  logic [CW-1:0] rel_ext;
  logic          wr_abs, wr_rel, wr_ctl, wr_ofs;

  assign wr_abs  = wr_en && (wr_sel == SEL_ABS);
  assign wr_rel  = wr_en && (wr_sel == SEL_REL);
  assign wr_ctl  = wr_en && (wr_sel == SEL_CTL);
  assign wr_ofs  = wr_en && (wr_sel == SEL_OFS);
  assign rel_ext = {{EXT_W{wr_data[RW-1]}}, wr_data[RW-1:0]};

  // compare value: absolute or relative load
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
    end else if (wr_abs) begin
      cmp_q <= wr_data;
    end else if (wr_rel) begin
      cmp_q <= adj_cnt + rel_ext;
    end
  end

  // control: only enable and mask are writable
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q.en   <= wr_data[CTL_EN_BIT];
      ctl_q.mask <= wr_data[CTL_MASK_BIT];
    end
  end

  generate
    if (IS_VIRTUAL) begin : g_virt
      logic [CW-1:0] ofs_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          ofs_r <= '0;
        end else if (wr_ofs) begin
          ofs_r <= wr_data;
        end
      end
      assign ofs_q = ofs_r;
    end else begin : g_phys
      assign ofs_q = '0;
    end
  endgenerate
endmodule

// File: rtl/cvt_compare.sv
module cvt_compare #(
  parameter int CW = 64,
  parameter int RW = 32
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] ofs,
  input  logic [CW-1:0] cmp,
  input  logic          en,
  output logic [CW-1:0] adj_cnt,
  output logic          status,
  output logic [RW-1:0] rel_val
);
  logic [CW-1:0] diff;
  logic          reached;

  assign adj_cnt = cnt_i - ofs;
  assign reached = (adj_cnt >= cmp);
  assign status  = en & reached;
  assign diff    = cmp - adj_cnt;
  assign rel_val = diff[RW-1:0];
endmodule

// File: rtl/cvt_readout.sv
module cvt_readout #(
  parameter int CW = 64,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  input  logic [CW-1:0] cmp,
  input  logic [RW-1:0] rel_val,
  input  cvt_pkg::ctl_t ctl,
  input  logic          status,
  input  logic [CW-1:0] ofs,
  output logic [CW-1:0] rd_data
);
  import cvt_pkg::*;

  logic [CW-1:0] ctl_word;
  logic [CW-1:0] rd_next;

  always_comb begin
    ctl_word               = '0;
    ctl_word[CTL_EN_BIT]   = ctl.en;
    ctl_word[CTL_MASK_BIT] = ctl.mask;
    ctl_word[CTL_STAT_BIT] = status;
  end

  always_comb begin
    case (rd_sel)
      SEL_ABS: rd_next = cmp;
      SEL_REL: rd_next = {{(CW-RW){1'b0}}, rel_val};
      SEL_CTL: rd_next = ctl_word;
      default: rd_next = ofs;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
  parameter int CW         = 64,
  parameter int RW         = 32,
  parameter bit IS_VIRTUAL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  output logic [CW-1:0] rd_data,
  output logic          irq_o
);
  import cvt_pkg::*;

  logic [CW-1:0] cmp_q;
  logic [CW-1:0] ofs_q;
  logic [CW-1:0] adj_cnt;
  logic [RW-1:0] rel_val;
  ctl_t          ctl_q;
  logic          status_w;
  logic          ctl_en, ctl_mask;

  assign ctl_en   = ctl_q.en;
  assign ctl_mask = ctl_q.mask;

  cvt_regs #(.CW(CW), .RW(RW), .IS_VIRTUAL(IS_VIRTUAL)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .adj_cnt (adj_cnt),
    .cmp_q   (cmp_q),
    .ctl_q   (ctl_q),
    .ofs_q   (ofs_q)
  );

  cvt_compare #(.CW(CW), .RW(RW)) u_cmp (
    .cnt_i   (cnt_i),
    .ofs     (ofs_q),
    .cmp     (cmp_q),
    .en      (ctl_en),
    .adj_cnt (adj_cnt),
    .status  (status_w),
    .rel_val (rel_val)
  );

  cvt_readout #(.CW(CW), .RW(RW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .cmp     (cmp_q),
    .rel_val (rel_val),
    .ctl     (ctl_q),
    .status  (status_w),
    .ofs     (ofs_q),
    .rd_data (rd_data)
  );

  // glitch-free level output
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= status_w & ~ctl_mask;
    end
  end
endmodule

// File: rtl/cvt_chk.sv
module cvt_chk #(
  parameter int CW = 64,
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_o,
  input logic          ctl_en,
  input logic          ctl_mask,
  input logic          status_w,
  input logic [CW-1:0] cmp_q,
  input logic [CW-1:0] adj_cnt,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [CW-1:0] wr_data
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_o && !ctl_en));

  // R3
  mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_mask) |-> !irq_o);

  // R3
  irq_needs_stat_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(status_w));

  // R4
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl_en) |-> !irq_o);

  // R4
  off_nostat_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |-> !status_w);

  // R2
  zero_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_en && cmp_q == '0) |-> status_w);

  // R5
  ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2) |=>
      (ctl_en == $past(wr_data[0]) && ctl_mask == $past(wr_data[1])));

  // R6
  rel_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1) |=>
      (cmp_q == $past(adj_cnt) + {{(CW-RW){$past(wr_data[RW-1])}}, $past(wr_data[RW-1:0])}));
endmodule

bind cmp_timer_chan cvt_chk #(.CW(CW), .RW(RW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_o    (irq_o),
  .ctl_en   (ctl_en),
  .ctl_mask (ctl_mask),
  .status_w (status_w),
  .cmp_q    (cmp_q),
  .adj_cnt  (adj_cnt),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data)
);

// File: tb/sim_cmp_timer_chan.sv
`timescale 1ns/1ps
module sim_cmp_timer_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd0, rd1;
  logic        irq0, irq1;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [63:0] r0, r1;

  always #5 clk = ~clk;

  cmp_timer_chan #(.IS_VIRTUAL(1'b1)) u0 (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd0), .irq_o(irq0));

  cmp_timer_chan #(.IS_VIRTUAL(1'b0)) u1 (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd1), .irq_o(irq1));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    r0 = rd0; r1 = rd1;
  endtask

  function automatic logic fires(input logic en, input logic [63:0] c,
                                 input logic [63:0] o, input logic [63:0] cm);
    return en && ((c - o) >= cm);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq0", {63'b0, irq0}, 64'd0);
    chk("R1 irq1", {63'b0, irq1}, 64'd0);
    rd(2'd2); chk("R1 ctl0", r0, 64'd0); chk("R1 ctl1", r1, 64'd0);
    rd(2'd0); chk("R1 cmp0", r0, 64'd0);
    rd(2'd3); chk("R1 ofs0", r0, 64'd0);

    // R2 R3 R4 R7 sweep over offset, count delta, enable and mask
    for (int oi = 0; oi < 2; oi++) begin
      for (int dl = -3; dl <= 3; dl++) begin
        for (int cm = 0; cm < 4; cm++) begin
          logic [63:0] o, c, cmpv;
          logic en, mk, s0, s1;
          o = (oi == 0) ? 64'd0 : 64'd5;
          cmpv = 64'd1000;
          c = cmpv + o + 64'(signed'(dl));
          en = cm[0]; mk = cm[1];
          wr(2'd3, o);
          wr(2'd0, cmpv);
          wr(2'd2, {62'd0, mk, en});
          cnt_i = c;
          @(negedge clk);
          s0 = fires(en, c, o, cmpv);
          s1 = fires(en, c, 64'd0, cmpv);
          chk("R3 irq virt", {63'b0, irq0}, {63'b0, s0 & ~mk});
          chk("R3 irq phys", {63'b0, irq1}, {63'b0, s1 & ~mk});
          rd(2'd2);
          chk("R2 ctl virt", r0, {61'd0, s0, mk, en});
          chk("R4 ctl phys", r1, {61'd0, s1, mk, en});
        end
      end
    end

    // R7 offset storage per variant
    wr(2'd3, 64'h1234_5678_9ABC_DEF0);
    rd(2'd3);
    chk("R7 ofs virt", r0, 64'h1234_5678_9ABC_DEF0);
    chk("R7 ofs phys", r1, 64'd0);

    // R9 wrap: compare near top, small count
    wr(2'd3, 64'd0);
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFF0);
    wr(2'd2, 64'd1);
    cnt_i = 64'd5;
    @(negedge clk);
    chk("R9 no fire", {63'b0, irq0}, 64'd0);
    // R9 count below offset fires
    wr(2'd3, 64'd10);
    wr(2'd0, 64'd1000);
    cnt_i = 64'd3;
    @(negedge clk);
    chk("R9 under ofs virt", {63'b0, irq0}, 64'd1);
    chk("R9 under ofs phys", {63'b0, irq1}, 64'd0);

    // R5 status bit not writable
    wr(2'd3, 64'd0);
    wr(2'd0, 64'd1000);
    cnt_i = 64'd10;
    wr(2'd2, 64'h7);
    rd(2'd2);
    chk("R5 ctl", r0, 64'h3);

    // R6 relative write, negative and positive; R8 readback
    wr(2'd3, 64'd100);
    cnt_i = 64'd500;
    wr(2'd1, 64'h0000_0000_FFFF_FFF6);
    rd(2'd0);
    chk("R6 neg rel", r0, 64'd390);
    chk("R6 neg rel phys", r1, 64'd490);
    wr(2'd1, 64'hABCD_0000_0000_0014);
    rd(2'd0);
    chk("R6 pos rel", r0, 64'd420);
    rd(2'd1);
    chk("R8 rel read", r0, 64'd20);
    cnt_i = 64'd510;
    rd(2'd1);
    chk("R8 rel read later", r0, 64'd10);
    cnt_i = 64'd600;
    rd(2'd1);
    chk("R8 rel read negative", r0, 64'h0000_0000_FFFF_FFB0);

    // R6 relative write with moving count: count at write edge used
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 64'd7; cnt_i = 64'd700;
    @(negedge clk);
    wr_en = 1'b0; cnt_i = 64'd900;
    rd(2'd0);
    chk("R6 moving count", r0, 64'd607);

    // R10 masked status, then unmask on the crossing cycle
    wr(2'd0, 64'd2000);
    cnt_i = 64'd2150;
    wr(2'd2, 64'h3);
    @(negedge clk);
    chk("R10 masked irq", {63'b0, irq0}, 64'd0);
    rd(2'd2);
    chk("R10 masked stat", r0, 64'h7);
    cnt_i = 64'd2000;
    wr(2'd2, 64'h3);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 64'h1; cnt_i = 64'd2100;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 irq not yet", {63'b0, irq0}, 64'd0);
    @(negedge clk);
    chk("R10 irq after unmask", {63'b0, irq0}, 64'd1);
    rd(2'd2);
    chk("R10 stat after unmask", r0, 64'h5);

    // R4 disable drops output
    wr(2'd2, 64'h0);
    @(negedge clk);
    chk("R4 disabled irq", {63'b0, irq0}, 64'd0);

    // R11 read hold without rd_en
    rd(2'd0);
    rd_sel = 2'd3;
    @(negedge clk);
    chk("R11 hold", rd0, 64'd2000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule